// File: doc/BRIEF.md
# Per-Port Status Pulse and Reference Generator

This block turns single-cycle per-port events into the visible status strobes of a four-port cell transceiver. All of it runs on the line oscillator clock, and every event input is assumed to be synchronous to that clock already. Each port has two active-low indicator lines:

- The receive indicator goes low for a fixed 223-cycle window whenever the port delivers a good cell. A good cell is one that is neither idle nor errored.
- The transmit indicator does the same whenever the port accepts a cell for sending.

A new event during a window restarts the full count.

A shared active-low receive reference line follows the timing markers of one port. A port-select input picks that port. A programmable width input sets how many cycles the line stays low. Widths 0 and 1 both give a single cycle. Running at clock multiples above 1x needs a width of at least 2. A marker that arrives while the line is low restarts the width count.

On the transmit side, a falling-edge detector watches the transmit reference input. For each falling edge it raises a one-cycle insert request on every port enabled in a port mask. The downstream framer uses that request to place a timing-marker command into its stream.

The state machines are named as follows:

- Each indicator runs a stretcher with states `LED_IDLE` and `LED_HOLD`.
  - `LED_IDLE` to `LED_HOLD` on a trigger.
  - `LED_HOLD` stays in `LED_HOLD` and reloads on a trigger.
  - `LED_HOLD` to `LED_IDLE` when the count is spent and no trigger is present.
- The reference generator has states `REF_IDLE` and `REF_DRIVE`, with the same transitions, driven by a marker on the selected port.
- The edge detector has states `EDGE_WAIT_HIGH` and `EDGE_ARMED`.
  - `EDGE_WAIT_HIGH` to `EDGE_ARMED` when the input is seen high.
  - `EDGE_ARMED` to `EDGE_WAIT_HIGH` when the input is seen low. This transition issues the request.
  - Reset enters `EDGE_WAIT_HIGH`.

Top module: `port_status_pulser`

## Requirements
- R1: A high `rx_good_cell[i]` at a clock edge drives `rx_led_n[i]` low from that edge for exactly 223 cycles, after which it returns high.
- R2: A high `tx_cell_accept[i]` at a clock edge drives `tx_led_n[i]` low from that edge for exactly 223 cycles.
- R3: A trigger during an active indicator window, including its final low cycle, restarts the 223-cycle count from that edge.
- R4: Each port's indicators respond only to that port's own events, so ports are independent.
- R5: A high `rx_marker[s]` on the port `s` named by `marker_port_sel` drives `rx_ref_n` low from that edge for `marker_width` cycles when the width is 2 or more.
- R6: A `marker_width` of 0 or of 1 gives a `rx_ref_n` low pulse of exactly one cycle.
- R7: Markers on ports other than the selected one have no effect on `rx_ref_n`.
- R8: A selected-port marker while `rx_ref_n` is low restarts the width count from that edge, using the width present at that edge.
- R9: A high-to-low transition of `tx_ref_n`, as sampled at consecutive edges, raises `tx_insert_req` equal to `tx_insert_mask` for exactly one cycle following the edge that samples the low. Holding the input low gives no further request.
- R10: During and right after reset, all indicator lines and `rx_ref_n` are high and `tx_insert_req` is zero. An input already low at reset release gives no request until it has been seen high and then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_good_cell | input | NUM_PORTS | Per-port good cell received, one-cycle strobe |
| tx_cell_accept | input | NUM_PORTS | Per-port cell accepted for transmit, one-cycle strobe |
| rx_marker | input | NUM_PORTS | Per-port timing-marker command received |
| marker_port_sel | input | PSEL_W | Port whose markers drive the reference output |
| marker_width | input | WIDTH_BITS | Reference pulse length in cycles (0 and 1 mean one) |
| tx_ref_n | input | 1 | Transmit reference; a falling edge requests marker insertion |
| tx_insert_mask | input | NUM_PORTS | Ports that receive an insert request |
| rx_led_n | output | NUM_PORTS | Active-low receive indicators |
| tx_led_n | output | NUM_PORTS | Active-low transmit indicators |
| rx_ref_n | output | 1 | Active-low receive reference pulse |
| tx_insert_req | output | NUM_PORTS | One-cycle per-port marker insert request |

## Verification
The two collisions of interest are:

- The expiry of a count and a fresh trigger landing in the same cycle. This happens on an indicator's final low cycle, and on a reference pulse that has one cycle left when a new selected-port marker arrives.
- A marker on the selected port coinciding with markers on unselected ports.

Directed sequences place the retrigger exactly 222 cycles after the first event, and place a second marker on the last cycle of a reference pulse. Random traffic fires events on all ports at once. The output is judged against a bench model that counts cycles since the last trigger. A collision is correct only when the line stays low without a single high cycle and then runs a full fresh window.

// File: rtl/status_pulse_pkg.sv
package status_pulse_pkg;

    typedef enum logic {
        LED_IDLE = 1'b0,
        LED_HOLD = 1'b1
    } led_state_e;

    typedef enum logic {
        REF_IDLE  = 1'b0,
        REF_DRIVE = 1'b1
    } ref_state_e;

    typedef enum logic {
        EDGE_WAIT_HIGH = 1'b0,
        EDGE_ARMED     = 1'b1
    } edge_state_e;

endpackage

// File: rtl/status_led_stretcher.sv
module status_led_stretcher
    import status_pulse_pkg::*;
#(
    parameter int HOLD_CYCLES = 223
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic led_n
);

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    led_state_e     state_q;
    led_state_e     state_d;
    logic [CW-1:0]  remain_q;
    logic           count_done;

    assign count_done = (remain_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LED_IDLE: begin
                if (trigger) begin
                    state_d = LED_HOLD;
                end
            end
            LED_HOLD: begin
                if (!trigger && count_done) begin
                    state_d = LED_IDLE;
                end
            end
            default: state_d = LED_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LED_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // remaining-cycle counter: reload on trigger, count down while holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (trigger) begin
            remain_q <= LOAD_VAL;
        end else if (state_q == LED_HOLD && !count_done) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        led_n = 1'b1;
        unique case (state_q)
            LED_IDLE: led_n = 1'b1;
            LED_HOLD: led_n = 1'b0;
            default:  led_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/status_ref_pulse.sv
module status_ref_pulse
    import status_pulse_pkg::*;
#(
    parameter int WIDTH_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  marker_hit,
    input  logic [WIDTH_BITS-1:0] width_cfg,
    output logic                  ref_n
);

    ref_state_e             state_q;
    ref_state_e             state_d;
    logic [WIDTH_BITS-1:0]  remain_q;
    logic [WIDTH_BITS-1:0]  load_val;
    logic                   count_done;

    // widths of 0 and 1 both collapse to a single low cycle
    always_comb begin
        if (width_cfg <= WIDTH_BITS'(1)) begin
            load_val = '0;
        end else begin
            load_val = width_cfg - 1'b1;
        end
    end

    assign count_done = (remain_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REF_IDLE: begin
                if (marker_hit) begin
                    state_d = REF_DRIVE;
                end
            end
            REF_DRIVE: begin
                if (!marker_hit && count_done) begin
                    state_d = REF_IDLE;
                end
            end
            default: state_d = REF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (marker_hit) begin
            remain_q <= load_val;
        end else if (state_q == REF_DRIVE && !count_done) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    always_comb begin
        ref_n = 1'b1;
        unique case (state_q)
            REF_IDLE:  ref_n = 1'b1;
            REF_DRIVE: ref_n = 1'b0;
            default:   ref_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/status_marker_edge.sv
module status_marker_edge
    import status_pulse_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_in_n,
    input  logic [NUM_PORTS-1:0] port_mask,
    output logic [NUM_PORTS-1:0] insert_req
);

    edge_state_e            state_q;
    edge_state_e            state_d;
    logic                   fire;
    logic [NUM_PORTS-1:0]   req_q;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            EDGE_WAIT_HIGH: begin
                if (ref_in_n) begin
                    state_d = EDGE_ARMED;
                end
            end
            EDGE_ARMED: begin
                if (!ref_in_n) begin
                    state_d = EDGE_WAIT_HIGH;
                    fire    = 1'b1;
                end
            end
            default: state_d = EDGE_WAIT_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDGE_WAIT_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // registered one-cycle request, gated per port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (fire) begin
            req_q <= port_mask;
        end else begin
            req_q <= '0;
        end
    end

    assign insert_req = req_q;

endmodule

// File: rtl/port_status_pulser.sv
module port_status_pulser
    import status_pulse_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int LED_CYCLES  = 223,
    parameter int WIDTH_BITS  = 4,
    parameter int PSEL_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PORTS-1:0]  rx_good_cell,
    input  logic [NUM_PORTS-1:0]  tx_cell_accept,
    input  logic [NUM_PORTS-1:0]  rx_marker,
    input  logic [PSEL_W-1:0]     marker_port_sel,
    input  logic [WIDTH_BITS-1:0] marker_width,
    input  logic                  tx_ref_n,
    input  logic [NUM_PORTS-1:0]  tx_insert_mask,
    output logic [NUM_PORTS-1:0]  rx_led_n,
    output logic [NUM_PORTS-1:0]  tx_led_n,
    output logic                  rx_ref_n,
    output logic [NUM_PORTS-1:0]  tx_insert_req
);

    localparam int SEL_SPAN = 2 ** PSEL_W;

    logic [SEL_SPAN-1:0] marker_pad;
    logic                sel_marker;

    // per-port indicator stretchers
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        status_led_stretcher #(
            .HOLD_CYCLES (LED_CYCLES)
        ) u_rx_led (
            .clk     (clk),
            .rst_n   (rst_n),
            .trigger (rx_good_cell[p]),
            .led_n   (rx_led_n[p])
        );

        status_led_stretcher #(
            .HOLD_CYCLES (LED_CYCLES)
        ) u_tx_led (
            .clk     (clk),
            .rst_n   (rst_n),
            .trigger (tx_cell_accept[p]),
            .led_n   (tx_led_n[p])
        );
    end

    // pick the selected port's marker; codes past the last port select nothing
    always_comb begin
        marker_pad                = '0;
        marker_pad[NUM_PORTS-1:0] = rx_marker;
        sel_marker                = marker_pad[marker_port_sel];
    end

    status_ref_pulse #(
        .WIDTH_BITS (WIDTH_BITS)
    ) u_ref_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .marker_hit (sel_marker),
        .width_cfg  (marker_width),
        .ref_n      (rx_ref_n)
    );

    status_marker_edge #(
        .NUM_PORTS (NUM_PORTS)
    ) u_marker_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in_n   (tx_ref_n),
        .port_mask  (tx_insert_mask),
        .insert_req (tx_insert_req)
    );

endmodule

// File: rtl/port_status_pulser_checks.sv
module port_status_pulser_checks #(
    parameter int NUM_PORTS   = 4,
    parameter int LED_CYCLES  = 223,
    parameter int WIDTH_BITS  = 4,
    parameter int PSEL_W      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PORTS-1:0]  rx_good_cell,
    input logic [NUM_PORTS-1:0]  tx_cell_accept,
    input logic [NUM_PORTS-1:0]  rx_marker,
    input logic [PSEL_W-1:0]     marker_port_sel,
    input logic [WIDTH_BITS-1:0] marker_width,
    input logic                  tx_ref_n,
    input logic [NUM_PORTS-1:0]  tx_insert_mask,
    input logic [NUM_PORTS-1:0]  rx_led_n,
    input logic [NUM_PORTS-1:0]  tx_led_n,
    input logic                  rx_ref_n,
    input logic [NUM_PORTS-1:0]  tx_insert_req
);

    localparam int SEL_SPAN = 2 ** PSEL_W;

    logic [SEL_SPAN-1:0] mk_pad;
    logic                mk_sel;
    int                  ref_left;

    always_comb begin
        mk_pad                = '0;
        mk_pad[NUM_PORTS-1:0] = rx_marker;
        mk_sel                = mk_pad[marker_port_sel];
    end

    // independent window counters: cycles elapsed since the last trigger
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        int rx_since;
        int tx_since;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rx_since <= LED_CYCLES;
                tx_since <= LED_CYCLES;
            end else begin
                if (rx_good_cell[p])          rx_since <= 0;
                else if (rx_since < LED_CYCLES) rx_since <= rx_since + 1;
                if (tx_cell_accept[p])        tx_since <= 0;
                else if (tx_since < LED_CYCLES) tx_since <= tx_since + 1;
            end
        end

        // R1 and R3: receive window length, restarts included
        assert_rx_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rx_led_n[p] == (rx_since >= LED_CYCLES));

        // R2 and R3: transmit window length
        assert_tx_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tx_led_n[p] == (tx_since >= LED_CYCLES));

        // R3: a trigger always leaves the indicator low on the next cycle
        assert_retrigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rx_good_cell[p] |=> !rx_led_n[p]);
    end

    // reference pulse model: remaining low cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_left <= 0;
        end else if (mk_sel) begin
            ref_left <= (int'(marker_width) <= 1) ? 1 : int'(marker_width);
        end else if (ref_left > 0) begin
            ref_left <= ref_left - 1;
        end
    end

    // R5, R6 and R8: reference low exactly while model cycles remain
    assert_ref_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ref_n == (ref_left == 0));

    // R7: a fall of the reference needs a selected-port marker one edge before
    assert_ref_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ref_n) |-> $past(mk_sel));

    // R9: request lasts a single cycle
    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_insert_req) |=> (tx_insert_req == '0));

    // R9 and R10: request only after a high-then-low input sequence
    assert_req_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_insert_req) |-> (!$past(tx_ref_n) && $past(tx_ref_n, 2)));

    // R9: only masked ports receive the request
    assert_req_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_insert_req) |-> ((tx_insert_req & ~$past(tx_insert_mask)) == '0));

    // R10: outputs idle while reset is applied
    always_comb begin
        if (!rst_n) begin
            assert_reset_idle_R10: assert ((&rx_led_n) && (&tx_led_n) && rx_ref_n
                                           && (tx_insert_req == '0));
        end
    end

endmodule

bind port_status_pulser port_status_pulser_checks #(
    .NUM_PORTS  (NUM_PORTS),
    .LED_CYCLES (LED_CYCLES),
    .WIDTH_BITS (WIDTH_BITS),
    .PSEL_W     (PSEL_W)
) u_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_good_cell    (rx_good_cell),
    .tx_cell_accept  (tx_cell_accept),
    .rx_marker       (rx_marker),
    .marker_port_sel (marker_port_sel),
    .marker_width    (marker_width),
    .tx_ref_n        (tx_ref_n),
    .tx_insert_mask  (tx_insert_mask),
    .rx_led_n        (rx_led_n),
    .tx_led_n        (tx_led_n),
    .rx_ref_n        (rx_ref_n),
    .tx_insert_req   (tx_insert_req)
);

// File: tb/port_status_pulser_bench.sv
`timescale 1ns/1ps
module port_status_pulser_bench;

    localparam int NP  = 4;
    localparam int LED = 223;
    localparam int WB  = 4;
    localparam int SW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] rx_good_cell = '0;
    logic [NP-1:0] tx_cell_accept = '0;
    logic [NP-1:0] rx_marker = '0;
    logic [SW-1:0] marker_port_sel = '0;
    logic [WB-1:0] marker_width = '0;
    logic          tx_ref_n = 1'b0;
    logic [NP-1:0] tx_insert_mask = '0;
    logic [NP-1:0] rx_led_n;
    logic [NP-1:0] tx_led_n;
    logic          rx_ref_n;
    logic [NP-1:0] tx_insert_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    int            m_rx_since [NP];
    int            m_tx_since [NP];
    int            m_ref_left;
    bit            m_armed;
    logic [NP-1:0] m_req;

    always #2.5 clk = ~clk;

    port_status_pulser #(
        .NUM_PORTS  (NP),
        .LED_CYCLES (LED),
        .WIDTH_BITS (WB)
    ) u_port_status_pulser (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_good_cell    (rx_good_cell),
        .tx_cell_accept  (tx_cell_accept),
        .rx_marker       (rx_marker),
        .marker_port_sel (marker_port_sel),
        .marker_width    (marker_width),
        .tx_ref_n        (tx_ref_n),
        .tx_insert_mask  (tx_insert_mask),
        .rx_led_n        (rx_led_n),
        .tx_led_n        (tx_led_n),
        .rx_ref_n        (rx_ref_n),
        .tx_insert_req   (tx_insert_req)
    );

    function automatic int eff_width(logic [WB-1:0] w);
        return (int'(w) <= 1) ? 1 : int'(w);
    endfunction

    function automatic logic [NP-1:0] exp_rx_led();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = (m_rx_since[i] >= LED);
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_tx_led();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = (m_tx_since[i] >= LED);
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NP; i++) begin
            m_rx_since[i] = LED;
            m_tx_since[i] = LED;
        end
        m_ref_left = 0;
        m_armed    = 1'b0;
        m_req      = '0;
    endtask

    // advance the model by one clock edge from the inputs held at that edge
    task automatic model_edge();
        for (int i = 0; i < NP; i++) begin
            if (rx_good_cell[i])      m_rx_since[i] = 0;
            else if (m_rx_since[i] < LED) m_rx_since[i]++;
            if (tx_cell_accept[i])    m_tx_since[i] = 0;
            else if (m_tx_since[i] < LED) m_tx_since[i]++;
        end
        if (rx_marker[marker_port_sel]) m_ref_left = eff_width(marker_width);
        else if (m_ref_left > 0)        m_ref_left--;
        m_req   = (m_armed && !tx_ref_n) ? tx_insert_mask : '0;
        m_armed = tx_ref_n;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "rx_led_n", 32'(rx_led_n), 32'(exp_rx_led()));
        check(tag, "tx_led_n", 32'(tx_led_n), 32'(exp_tx_led()));
        check(tag, "rx_ref_n", 32'(rx_ref_n), 32'(m_ref_left == 0));
        check(tag, "tx_insert_req", 32'(tx_insert_req), 32'(m_req));
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R10: idle outputs while held in reset
        check("R10", "rx_led_n", 32'(rx_led_n), 32'hF);
        check("R10", "rx_ref_n", 32'(rx_ref_n), 32'h1);
        rst_n = 1'b1;
        // R10: input low at release must not request
        idle(3, "R10");

        // R1: single good cell on port 0
        rx_good_cell = 4'b0001;
        step("R1");
        rx_good_cell = '0;
        idle(230, "R1");

        // R2: transmit accept on port 2
        tx_cell_accept = 4'b0100;
        step("R2");
        tx_cell_accept = '0;
        idle(230, "R2");

        // R3: retrigger exactly on the final low cycle
        rx_good_cell = 4'b0010;
        step("R3");
        rx_good_cell = '0;
        idle(LED - 2, "R3");
        rx_good_cell = 4'b0010;
        step("R3");
        rx_good_cell = '0;
        idle(LED + 4, "R3");

        // R5: width 5 on selected port 1
        marker_port_sel = 2'd1;
        marker_width    = 4'd5;
        rx_marker = 4'b0010;
        step("R5");
        rx_marker = '0;
        idle(8, "R5");

        // R7: marker on unselected ports only
        rx_marker = 4'b1101;
        step("R7");
        rx_marker = '0;
        idle(4, "R7");

        // R6: widths 0 and 1
        for (int w = 0; w < 2; w++) begin
            marker_width = WB'(w);
            rx_marker = 4'b0010;
            step("R6");
            rx_marker = '0;
            idle(3, "R6");
        end

        // R8: restart mid-pulse and on the last low cycle
        marker_width = 4'd8;
        rx_marker = 4'b0010;
        step("R8");
        rx_marker = '0;
        idle(2, "R8");
        rx_marker = 4'b0010;
        step("R8");
        rx_marker = '0;
        idle(6, "R8");
        rx_marker = 4'b0010;
        step("R8");
        rx_marker = '0;
        idle(10, "R8");

        // R9: falling edges of transmit reference with a mask
        tx_insert_mask = 4'b1010;
        tx_ref_n = 1'b1;
        idle(2, "R9");
        tx_ref_n = 1'b0;
        idle(5, "R9");
        tx_ref_n = 1'b1;
        step("R9");
        tx_insert_mask = 4'b0111;
        tx_ref_n = 1'b0;
        idle(3, "R9");

        // R4: random traffic on all ports, all functions colliding
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NP; i++) begin
                rx_good_cell[i]   = ($urandom % 97) == 0;
                tx_cell_accept[i] = ($urandom % 89) == 0;
                rx_marker[i]      = ($urandom % 23) == 0;
            end
            if (($urandom % 50) == 0) marker_port_sel = SW'($urandom);
            if (($urandom % 40) == 0) marker_width    = WB'($urandom);
            if (($urandom % 7) == 0)  tx_ref_n        = ~tx_ref_n;
            if (($urandom % 30) == 0) tx_insert_mask  = NP'($urandom);
            step("R4");
        end
        rx_good_cell   = '0;
        tx_cell_accept = '0;
        rx_marker      = '0;
        idle(LED + 2, "R4");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule